// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period timer. The timer advances once every four system clocks times a selectable prescale ratio of 1, 4 or 16. When the timer has reached the programmed period value, the next advance starts a new period: the timer returns to zero and the output rises. A 10-bit compare base is formed from the timer and two fine bits. When that base reaches the programmed duty value, the output falls.

Software-side logic writes the duty value at any moment as an 8-bit upper part and a 2-bit lower part, each with its own write strobe. Both parts go into a staging buffer. The buffer is copied into a hidden active duty register only at a period boundary, so a write can never shorten or lengthen a pulse that is already in progress. A one-clock strobe marks each period boundary, and the current timer value is presented as an output.

Top module: `pwm_shadow_top`

## Requirements
- R1: While reset is asserted, and in the clock after `enable` is low, `pwmOut` and `periodMatch` are 0 and `timerValue` is 0.
- R2: While enabled, `periodMatch` pulses for exactly one clock once per period. The distance between pulses is (periodReg + 1) × 4 × ratio clocks.
- R3: The `preSel` encoding is 00 → ratio 1, 01 → ratio 4, 10 and 11 → ratio 16. The timer advances once every 4 × ratio clocks.
- R4: In the clock where `periodMatch` is 1, `timerValue` is 0. In the clock before it, `timerValue` equals `periodReg`. `pwmOut` rises in the same clock as `periodMatch` when the newly loaded duty is nonzero.
- R5: With duty D = {upper 8 bits, lower 2 bits} and 0 < D ≤ 4 × (periodReg + 1), `pwmOut` is high for exactly D × ratio clocks per period. D = 4 × (periodReg + 1) gives an output that is high for the whole period.
- R6: A duty of 0 keeps `pwmOut` low for the entire period.
- R7: A duty write during a period leaves that period's pulse width unchanged. The new value governs the width from the next period onward.
- R8: A duty greater than 4 × (periodReg + 1) is never reached by the compare base, so `pwmOut` stays high continuously.
- R9: After `enable` rises, the first period starts with `timerValue` at 0. It lasts one full period with `pwmOut` low, because the active duty was cleared while the block was disabled.
- R10: The upper and lower duty parts are written independently. A write to one part leaves the other part's staged value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the timer when high; clears the timer and output when low |
| preSel | input | 2 | Prescale select: 00 = 1, 01 = 4, 1x = 16 |
| periodReg | input | 8 | Last timer value of a period |
| dutyHiWr | input | 1 | Write strobe for the upper 8 duty bits |
| dutyHiData | input | 8 | Upper duty bits |
| dutyLoWr | input | 1 | Write strobe for the lower 2 duty bits |
| dutyLoData | input | 2 | Lower duty bits |
| pwmOut | output | 1 | PWM output |
| periodMatch | output | 1 | One-clock strobe at each period start |
| timerValue | output | 8 | Current timer value |

## Verification
Pulse width and period are measured in clocks under all three prescale ratios, using small period values with odd duties. This separates a fine-bit selection error from a timer-rate error, because each fault shifts the width by a different factor. Duties of zero, exactly the period, and above the period expose off-by-one faults in the compare and in the zero-suppression path. A duty rewrite in the middle of a pulse, and writes to only the lower or only the upper part, show whether the staging buffer and the rollover load keep the two halves and the two periods apart.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  // Strobes from the timer control to the duty datapath.
  typedef struct packed {
    logic fineStep;  // compare base advances at the coming edge
    logic roll;      // period ends at the coming edge
  } ctrlStb_t;

  // Prescale select encoding.
  localparam logic [1:0] PRE_DIV1 = 2'b00;
  localparam logic [1:0] PRE_DIV4 = 2'b01;

endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        preSel,
  input  logic [TMR_W-1:0]  periodReg,
  output logic [TMR_W-1:0]  tmrQ,
  output logic [FINE_W-1:0] fineBits,
  output ctrlStb_t          stb
);

  localparam int LEVELS = 3;                // ratios 1, 4, 16
  localparam int CNT_W  = FINE_W * LEVELS;  // phase bits plus prescaler bits

  logic [CNT_W-1:0]  cntQ;
  logic [FINE_W-1:0] fineLvl [LEVELS];
  logic [LEVELS-1:0] tickLvl;
  logic [LEVELS-1:0] stepLvl;
  logic [1:0]        lvlSel;
  logic              tick;
  logic              roll;

  // One slice of the phase/prescale counter per ratio level.
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign fineLvl[g] = cntQ[(g+1)*FINE_W-1 : g*FINE_W];
    assign tickLvl[g] = &cntQ[(g+1)*FINE_W-1 : 0];
    if (g == 0) begin : g_first
      assign stepLvl[g] = 1'b1;
    end else begin : g_rest
      assign stepLvl[g] = &cntQ[g*FINE_W-1 : 0];
    end
  end

  always_comb begin
    case (preSel)
      PRE_DIV1: lvlSel = 2'd0;
      PRE_DIV4: lvlSel = 2'd1;
      default:  lvlSel = 2'd2;
    endcase
  end

  assign tick     = enable && tickLvl[lvlSel];
  assign roll     = tick && (tmrQ == periodReg);
  assign fineBits = fineLvl[lvlSel];

  always_comb begin
    stb.fineStep = enable && stepLvl[lvlSel];
    stb.roll     = roll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      tmrQ <= '0;
    end else if (!enable) begin
      cntQ <= '0;
      tmrQ <= '0;
    end else begin
      cntQ <= tick ? '0 : cntQ + 1'b1;
      if (roll)      tmrQ <= '0;
      else if (tick) tmrQ <= tmrQ + 1'b1;
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (tmrQ == '0) && (cntQ == '0)); // R1
  AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    roll |=> tmrQ == '0); // R4
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tick && !roll) |=> tmrQ == TMR_W'($past(tmrQ) + 1'b1)); // R3
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tick) |=> $stable(tmrQ)); // R3

endmodule

// File: rtl/pwm_duty_path.sv
module pwm_duty_path
  import pwm_shadow_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  ctrlStb_t          stb,
  input  logic [TMR_W-1:0]  tmrQ,
  input  logic [FINE_W-1:0] fineBits,
  input  logic              hiWr,
  input  logic [TMR_W-1:0]  hiData,
  input  logic              loWr,
  input  logic [FINE_W-1:0] loData,
  output logic              pwmOut,
  output logic              periodMatch
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  hiBuf;
  logic [FINE_W-1:0] loBuf;
  logic [DUTY_W-1:0] stagedDuty;
  logic [DUTY_W-1:0] activeDuty;
  logic [DUTY_W-1:0] baseVal;
  logic              hitEnd;
  logic              pinQ;
  logic              matchQ;

  assign stagedDuty = {hiBuf, loBuf};
  assign baseVal    = {tmrQ, fineBits};
  // Falls on the base step that lands on the active duty.
  assign hitEnd     = stb.fineStep && (activeDuty != '0) &&
                      (baseVal == activeDuty - DUTY_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiBuf <= '0;
      loBuf <= '0;
    end else begin
      if (hiWr) hiBuf <= hiData;
      if (loWr) loBuf <= loData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDuty <= '0;
      pinQ       <= 1'b0;
      matchQ     <= 1'b0;
    end else if (!enable) begin
      activeDuty <= '0;
      pinQ       <= 1'b0;
      matchQ     <= 1'b0;
    end else begin
      matchQ <= stb.roll;
      if (stb.roll) begin
        activeDuty <= stagedDuty;
        pinQ       <= (stagedDuty != '0);
      end else if (hitEnd) begin
        pinQ <= 1'b0;
      end
    end
  end

  assign pwmOut      = pinQ;
  assign periodMatch = matchQ;

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut && !periodMatch); // R1
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (activeDuty == '0 && !stb.roll) |=> !pwmOut); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !stb.roll) |=> $stable(activeDuty)); // R7
  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.roll |=> activeDuty == $past(stagedDuty)); // R7
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    periodMatch |-> tmrQ == '0); // R4

endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
  import pwm_shadow_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        preSel,
  input  logic [TMR_W-1:0]  periodReg,
  input  logic              dutyHiWr,
  input  logic [TMR_W-1:0]  dutyHiData,
  input  logic              dutyLoWr,
  input  logic [FINE_W-1:0] dutyLoData,
  output logic              pwmOut,
  output logic              periodMatch,
  output logic [TMR_W-1:0]  timerValue
);

  ctrlStb_t          stb;
  logic [TMR_W-1:0]  tmrQ;
  logic [FINE_W-1:0] fineBits;

  pwm_timer_ctrl #(.TMR_W(TMR_W), .FINE_W(FINE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .preSel   (preSel),
    .periodReg(periodReg),
    .tmrQ     (tmrQ),
    .fineBits (fineBits),
    .stb      (stb)
  );

  pwm_duty_path #(.TMR_W(TMR_W), .FINE_W(FINE_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .stb        (stb),
    .tmrQ       (tmrQ),
    .fineBits   (fineBits),
    .hiWr       (dutyHiWr),
    .hiData     (dutyHiData),
    .loWr       (dutyLoWr),
    .loData     (dutyLoData),
    .pwmOut     (pwmOut),
    .periodMatch(periodMatch)
  );

  assign timerValue = tmrQ;

endmodule

// File: tb/test_pwm_shadow_top.sv
module test_pwm_shadow_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] preSel = 2'b00;
  logic [7:0] periodReg = 8'd0;
  logic       dutyHiWr = 1'b0;
  logic [7:0] dutyHiData = 8'd0;
  logic       dutyLoWr = 1'b0;
  logic [1:0] dutyLoData = 2'd0;
  logic       pwmOut;
  logic       periodMatch;
  logic [7:0] timerValue;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  pwm_shadow_top i_pwm_shadow_top (
    .clk(clk), .rstN(rstN), .enable(enable), .preSel(preSel),
    .periodReg(periodReg), .dutyHiWr(dutyHiWr), .dutyHiData(dutyHiData),
    .dutyLoWr(dutyLoWr), .dutyLoData(dutyLoData), .pwmOut(pwmOut),
    .periodMatch(periodMatch), .timerValue(timerValue)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeDuty(input int d, input bit doHi, input bit doLo);
    dutyHiData = 8'(d >> 2); dutyLoData = 2'(d);
    dutyHiWr = doHi; dutyLoWr = doLo;
    @(negedge clk);
    dutyHiWr = 1'b0; dutyLoWr = 1'b0;
  endtask

  // Disable, load settings, then enable; checks the first period (R9).
  task automatic startRun(input logic [1:0] ps, input int pr, input int d, input int ratio);
    int n = 0;
    int hi = 0;
    enable = 1'b0; @(negedge clk);
    preSel = ps; periodReg = 8'(pr);
    writeDuty(d, 1'b1, 1'b1);
    enable = 1'b1;
    @(negedge clk);
    check(timerValue == 8'd0, "R9 timer at start", int'(timerValue), 0);
    n = 1; hi = int'(pwmOut);
    while (!periodMatch && n < 20000) begin
      @(negedge clk); n++;
      if (!periodMatch) hi += int'(pwmOut);
    end
    check(n == (pr + 1) * 4 * ratio, "R9 first period length", n, (pr + 1) * 4 * ratio);
    check(hi == 0, "R9 first period low", hi, 0);
  endtask

  // Called at the negedge of a match clock; counts one full period.
  task automatic measure(output int per, output int hi, input int pr);
    int prevTmr = 0;
    per = 0; hi = 0;
    check(timerValue == 8'd0, "R4 timer zero at match", int'(timerValue), 0);
    do begin
      hi += int'(pwmOut); per++; prevTmr = int'(timerValue);
      @(negedge clk);
      if (per == 1 && pr > 0)
        check(!periodMatch, "R2 match one clock", int'(periodMatch), 0);
    end while (!periodMatch && per < 20000);
    check(prevTmr == pr, "R4 timer before match", prevTmr, pr);
  endtask

  task automatic checkPeriod(input int pr, input int ratio, input int expHi, input string tag);
    int per;
    int hi;
    measure(per, hi, pr);
    check(per == (pr + 1) * 4 * ratio, {tag, " period"}, per, (pr + 1) * 4 * ratio);
    check(hi == expHi, {tag, " high"}, hi, expHi);
  endtask

  task automatic testReset();
    check(!pwmOut && !periodMatch && timerValue == 8'd0, "R1 reset state",
          int'({pwmOut, periodMatch}) + int'(timerValue), 0);
  endtask

  task automatic testRatios();
    startRun(2'b00, 9, 22, 1);
    check(pwmOut == 1'b1, "R4 pin rises with match", int'(pwmOut), 1);
    checkPeriod(9, 1, 22, "R5 R2 ratio1");
    checkPeriod(9, 1, 22, "R5 ratio1 repeat");
    startRun(2'b01, 4, 7, 4);
    checkPeriod(4, 4, 28, "R3 ratio4");
    startRun(2'b10, 2, 5, 16);
    checkPeriod(2, 16, 80, "R3 ratio16");
    startRun(2'b11, 2, 1, 16);
    checkPeriod(2, 16, 16, "R3 ratio16 alt code");
  endtask

  task automatic testEdges();
    startRun(2'b00, 9, 0, 1);
    check(pwmOut == 1'b0, "R6 no rise at zero duty", int'(pwmOut), 0);
    checkPeriod(9, 1, 0, "R6 zero duty");
    startRun(2'b00, 9, 40, 1);
    checkPeriod(9, 1, 40, "R5 full duty");
    startRun(2'b00, 9, 100, 1);
    checkPeriod(9, 1, 40, "R8 over period");
    checkPeriod(9, 1, 40, "R8 stays high");
    startRun(2'b00, 0, 1, 1);
    checkPeriod(0, 1, 1, "R5 smallest period");
  endtask

  task automatic testMidWrite();
    int per = 0;
    int hi = 0;
    startRun(2'b00, 9, 22, 1);
    do begin
      hi += int'(pwmOut); per++;
      if (per == 5) begin
        dutyHiData = 8'd2; dutyLoData = 2'd2; dutyHiWr = 1'b1; dutyLoWr = 1'b1;
      end
      @(negedge clk);
      dutyHiWr = 1'b0; dutyLoWr = 1'b0;
    end while (!periodMatch && per < 20000);
    check(hi == 22, "R7 current period keeps width", hi, 22);
    checkPeriod(9, 1, 10, "R7 next period new width");
  endtask

  task automatic testHalves();
    startRun(2'b00, 9, 22, 1);
    writeDuty(1, 1'b0, 1'b1);                 // lower part only: D=21
    while (!periodMatch) @(negedge clk);
    checkPeriod(9, 1, 21, "R10 lower write only");
    writeDuty(2 << 2, 1'b1, 1'b0);            // upper part only: D=9
    while (!periodMatch) @(negedge clk);
    checkPeriod(9, 1, 9, "R10 upper write only");
  endtask

  task automatic testDisable();
    startRun(2'b00, 9, 30, 1);
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b1, "R1 running high", int'(pwmOut), 1);
    enable = 1'b0;
    @(negedge clk);
    check(!pwmOut && !periodMatch && timerValue == 8'd0, "R1 cleared when disabled",
          int'(pwmOut) + int'(timerValue), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testRatios();
    testEdges();
    testMidWrite();
    testHalves();
    testDisable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule